// File: doc/BRIEF.md
# Banked Shared Scratchpad Memory

This block is the on-chip scratchpad that the work-items of one group share. It holds 64 KB as 32 banks, each one 32-bit word wide. A request names one byte address per lane for 64 lanes, plus an active-lane mask, a read or write flag, an access size and one write word per lane. Because there are half as many banks as lanes, the block serves the lower 32 lanes first and the upper 32 lanes after them. In the conflict-free case each half takes one bank cycle, so the banks deliver 32 words per clock.

Inside a half, an arbiter for each bank grants the lowest-numbered pending lane that maps to that bank. In the same cycle it also serves every other pending lane that names the same row of that bank. A lane that names a different row of a busy bank waits for a later pass. A separate broadcast mode reads one location and returns it to all 64 lanes after a single access.

Coherency is left to software. There is no tag lookup and no hardware coherency. The response is a one-cycle valid pulse that carries all 64 lane results together. The request side accepts nothing while an operation is in flight.

Top module: `spm_scratchpad`

## Requirements
- R1: Storage is 32 banks of 512 words of 32 bits, addressed by a 16-bit byte address. Bits [6:2] pick the bank and bits [15:7] pick the row, so every word of the 64 KB range can be written and read back, the lowest and the highest included.
- R2: An index-mode request with no bank conflict in either half raises rsp_valid after exactly 2 clock edges past the edge that accepted it. Each lane receives the word at its own address.
- R3: Within one half, each further distinct row that active lanes place on one bank adds one cycle. A half takes as many cycles as the largest number of distinct rows on any single bank, and never fewer than 1. The data stays correct.
- R4: Active lanes in one half that name the same word share one access and add no cycle.
- R5: Broadcast mode (req_bcast=1) reads the address in lane 0, ignores the mask and the write flag, and returns that value on all 64 lanes. rsp_valid rises 1 edge after acceptance.
- R6: req_size encodes 2'b00 as a 32-bit read, 2'b01 as a 16-bit read and 2'b10 as an 8-bit read. A 16-bit read takes the upper half of the word when address bit 1 is set. An 8-bit read takes byte address[1:0]. Sub-word results are zero-extended.
- R7: Inactive lanes (mask bit 0) make no access. They write nothing, add no conflict cycles, and return 0 in index mode.
- R8: A write stores a full word at the word address and ignores address bits [1:0]. When several active lanes write the same word in one request, the highest-numbered lane's data remains. A write response returns 0 on every lane. A later read sees the written data.
- R9: req_ready is high only when idle. It falls on the accepting edge and stays low until rsp_valid has pulsed for exactly one cycle. req_valid has no effect while req_ready is low.
- R10: After reset, req_ready is 1 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = word write, 0 = read |
| req_bcast | input | 1 | 1 = broadcast mode using the lane-0 address |
| req_size | input | 2 | Read size: 00 word, 01 half, 10 byte |
| req_mask | input | 64 | Active lanes |
| req_addr | input | 1024 | Per-lane 16-bit byte address, lane l at [16l+15:16l] |
| req_wdata | input | 2048 | Per-lane write word, lane l at [32l+31:32l] |
| rsp_valid | output | 1 | One-cycle pulse with all lane results |
| rsp_data | output | 2048 | Per-lane result, lane l at [32l+31:32l] |

## Verification
Index reads are tried with five lane-address strides, each of which separates one behaviour from the others:
- a unit word stride, where there is no conflict;
- a zero stride, where every lane shares one word;
- a stride of two words, which gives two rows per bank;
- a stride of one row, which gives 32 rows on one bank;
- byte and half-word strides, where lanes share words and the extraction is exercised.

Masked variants of the worst-conflict stride show whether inactive lanes are kept out of the arbitration. For writes, a same-address write from every lane shows whether the highest lane wins. Broadcast reads at the two ends of the address space and a request held high while the block is busy complete the set.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int WORD_W    = 32;
    localparam int DEF_LANES = 64;
    localparam int DEF_BANKS = 32;
    localparam int DEF_ROWS  = 512;
    localparam int DEF_AW    = 16;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_HALF = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_BCAST,
        ST_DONE
    } phase_e;

    typedef struct packed {
        logic  wr;
        logic  bcast;
        size_e size;
    } ctl_t;

    // Select a sub-word field of a stored word and zero-extend it.
    function automatic logic [WORD_W-1:0] pick_field(input logic [WORD_W-1:0] w,
                                                     input logic [1:0] boff,
                                                     input size_e sz);
        logic [WORD_W-1:0] r;
        r = w;
        case (sz)
            SZ_HALF: r = boff[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
            SZ_BYTE: begin
                case (boff)
                    2'd0:    r = {24'h0, w[7:0]};
                    2'd1:    r = {24'h0, w[15:8]};
                    2'd2:    r = {24'h0, w[23:16]};
                    default: r = {24'h0, w[31:24]};
                endcase
            end
            default: r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spm_bank_arb.sv
module spm_bank_arb #(
    parameter int HALF    = 32,
    parameter int BW      = 5,
    parameter int RW      = 9,
    parameter int WW      = 32,
    parameter int BANK_ID = 0
) (
    input  logic [HALF-1:0] pend,
    input  logic [BW-1:0]   bank_of [HALF],
    input  logic [RW-1:0]   row_of  [HALF],
    input  logic [WW-1:0]   wd_of   [HALF],
    output logic            en,
    output logic [RW-1:0]   row,
    output logic [WW-1:0]   wd,
    output logic [HALF-1:0] serve
);

    logic [HALF-1:0] hit;

    always_comb begin
        for (int i = 0; i < HALF; i++) begin
            hit[i] = pend[i] && (bank_of[i] == BW'(BANK_ID));
        end
    end

    // Lowest-numbered hitting lane picks the row; all lanes on that row ride along.
    always_comb begin
        en  = 1'b0;
        row = '0;
        for (int i = 0; i < HALF; i++) begin
            if (hit[i] && !en) begin
                en  = 1'b1;
                row = row_of[i];
            end
        end
    end

    // Highest-numbered served lane supplies the write word.
    always_comb begin
        wd    = '0;
        serve = '0;
        for (int i = 0; i < HALF; i++) begin
            if (hit[i] && (row_of[i] == row)) begin
                serve[i] = 1'b1;
                wd       = wd_of[i];
            end
        end
    end

endmodule

// File: rtl/spm_bank_mem.sv
module spm_bank_mem #(
    parameter int ROWS = 512,
    parameter int WW   = 32,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [WW-1:0] wd,
    output logic [WW-1:0] rd
);

    logic [WW-1:0] store [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            store[row] <= wd;
        end
    end

    assign rd = store[row];

endmodule

// File: rtl/spm_scratchpad.sv
module spm_scratchpad
    import spm_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int BANKS = DEF_BANKS,
    parameter int ROWS  = DEF_ROWS,
    parameter int AW    = DEF_AW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic                    req_bcast,
    input  logic [1:0]              req_size,
    input  logic [LANES-1:0]        req_mask,
    input  logic [LANES*AW-1:0]     req_addr,
    input  logic [LANES*WORD_W-1:0] req_wdata,
    output logic                    rsp_valid,
    output logic [LANES*WORD_W-1:0] rsp_data
);

    localparam int HALF = LANES / 2;
    localparam int BW   = $clog2(BANKS);
    localparam int RW   = $clog2(ROWS);
    localparam int WW   = WORD_W;

    phase_e          st;
    ctl_t            ctl;
    logic [HALF-1:0] mask_hi_q;
    logic [HALF-1:0] pend_q;
    logic [BW-1:0]   bank_q [LANES];
    logic [RW-1:0]   row_q  [LANES];
    logic [1:0]      boff_q [LANES];
    logic [WW-1:0]   wd_q   [LANES];
    logic [WW-1:0]   res_q  [LANES];

    logic [BW-1:0]   h_bank [HALF];
    logic [RW-1:0]   h_row  [HALF];
    logic [1:0]      h_boff [HALF];
    logic [WW-1:0]   h_wd   [HALF];
    logic [WW-1:0]   lane_rd[HALF];
    logic [HALF-1:0] arb_pend;
    logic [HALF-1:0] serve_b [BANKS];
    logic [HALF-1:0] serve;
    logic [HALF-1:0] pend_left;
    logic [BANKS-1:0] b_en;
    logic [RW-1:0]   b_row [BANKS];
    logic [WW-1:0]   b_wd  [BANKS];
    logic [WW-1:0]   b_rd  [BANKS];
    logic            hi;

    assign hi = (st == ST_HI);

    // Present the active half of the wave to the bank arbiters.
    always_comb begin
        for (int i = 0; i < HALF; i++) begin
            h_bank[i] = hi ? bank_q[HALF+i] : bank_q[i];
            h_row[i]  = hi ? row_q[HALF+i]  : row_q[i];
            h_boff[i] = hi ? boff_q[HALF+i] : boff_q[i];
            h_wd[i]   = hi ? wd_q[HALF+i]   : wd_q[i];
        end
        if (st == ST_BCAST)
            arb_pend = HALF'(1);
        else if (st == ST_LO || st == ST_HI)
            arb_pend = pend_q;
        else
            arb_pend = '0;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        spm_bank_arb #(
            .HALF(HALF), .BW(BW), .RW(RW), .WW(WW), .BANK_ID(b)
        ) i_arb (
            .pend   (arb_pend),
            .bank_of(h_bank),
            .row_of (h_row),
            .wd_of  (h_wd),
            .en     (b_en[b]),
            .row    (b_row[b]),
            .wd     (b_wd[b]),
            .serve  (serve_b[b])
        );

        spm_bank_mem #(
            .ROWS(ROWS), .WW(WW)
        ) i_mem (
            .clk(clk),
            .we (b_en[b] & ctl.wr),
            .row(b_row[b]),
            .wd (b_wd[b]),
            .rd (b_rd[b])
        );
    end

    always_comb begin
        serve = '0;
        for (int b = 0; b < BANKS; b++) begin
            serve = serve | serve_b[b];
        end
        pend_left = pend_q & ~serve;
        for (int i = 0; i < HALF; i++) begin
            lane_rd[i] = pick_field(b_rd[h_bank[i]], h_boff[i], ctl.size);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ctl       <= '0;
            mask_hi_q <= '0;
            pend_q    <= '0;
            for (int l = 0; l < LANES; l++) begin
                res_q[l] <= '0;
            end
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctl.wr    <= req_write & ~req_bcast;
                        ctl.bcast <= req_bcast;
                        ctl.size  <= size_e'(req_size);
                        mask_hi_q <= req_mask[LANES-1:HALF];
                        pend_q    <= req_mask[HALF-1:0];
                        for (int l = 0; l < LANES; l++) begin
                            bank_q[l] <= req_addr[l*AW+2 +: BW];
                            row_q[l]  <= req_addr[l*AW+2+BW +: RW];
                            boff_q[l] <= req_addr[l*AW +: 2];
                            wd_q[l]   <= req_wdata[l*WW +: WW];
                            res_q[l]  <= '0;
                        end
                        st <= req_bcast ? ST_BCAST : ST_LO;
                    end
                end
                ST_LO: begin
                    for (int i = 0; i < HALF; i++) begin
                        if (serve[i] && !ctl.wr) res_q[i] <= lane_rd[i];
                    end
                    if (pend_left == '0) begin
                        pend_q <= mask_hi_q;
                        st     <= ST_HI;
                    end else begin
                        pend_q <= pend_left;
                    end
                end
                ST_HI: begin
                    for (int i = 0; i < HALF; i++) begin
                        if (serve[i] && !ctl.wr) res_q[HALF+i] <= lane_rd[i];
                    end
                    if (pend_left == '0) begin
                        pend_q <= '0;
                        st     <= ST_DONE;
                    end else begin
                        pend_q <= pend_left;
                    end
                end
                ST_BCAST: begin
                    for (int l = 0; l < LANES; l++) begin
                        res_q[l] <= lane_rd[0];
                    end
                    st <= ST_DONE;
                end
                ST_DONE:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign rsp_valid = (st == ST_DONE);

    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign rsp_data[l*WW +: WW] = res_q[l];
    end

    // R3: a half with lanes still pending always retires at least one of them.
    p_progress_r3: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_LO || st == ST_HI) && pend_q != '0) |-> (serve != '0));

    // R9: acceptance makes the block busy on the next cycle.
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9: the response lasts one cycle and the block is idle afterwards.
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R5: a broadcast access is followed directly by the response.
    p_bcast_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BCAST) |=> rsp_valid);

    // R8: write passes leave the lane results untouched.
    p_write_no_capture_r8: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_LO || st == ST_HI) && ctl.wr) |=> $stable(rsp_data));

endmodule

// File: tb/test_spm_scratchpad.sv
`timescale 1ns/1ps
module test_spm_scratchpad;

    localparam int L = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_ready, req_write, req_bcast;
    logic [1:0]    req_size;
    logic [L-1:0]  req_mask;
    logic [L*16-1:0] req_addr;
    logic [L*32-1:0] req_wdata;
    logic          rsp_valid;
    logic [L*32-1:0] rsp_data;
    logic [L*32-1:0] rdat;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spm_scratchpad i_spm_scratchpad (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bcast(req_bcast), .req_size(req_size),
        .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Stimulus table: stride, base, size, mask, expected latency, requirement.
    localparam int NV = 9;
    localparam int T_STRIDE [NV] = '{4, 0, 8, 128, 1, 2, 128, 4, 128};
    localparam int T_BASE   [NV] = '{0, 'h100, 0, 0, 'h200, 'h300, 0, 4, 0};
    localparam int T_SIZE   [NV] = '{0, 0, 0, 0, 2, 1, 0, 0, 0};
    localparam logic [63:0] T_MASK [NV] = '{
        {64{1'b1}}, {64{1'b1}}, {64{1'b1}}, {64{1'b1}}, {64{1'b1}}, {64{1'b1}},
        64'h0000_0001_0000_0001, 64'h5555_5555_5555_5555, 64'h0000_0003_0000_0003};
    localparam int T_LAT    [NV] = '{2, 2, 4, 64, 2, 2, 2, 2, 4};
    localparam string T_REQ [NV] = '{"R2", "R4", "R3", "R3", "R6", "R6", "R7", "R7", "R3"};

    function automatic logic [31:0] fill(input int idx);
        logic [13:0] k;
        k = idx[13:0];
        return {k, 2'b01, ~k, 2'b10};
    endfunction

    function automatic logic [31:0] ext(input logic [31:0] w, input logic [1:0] bo, input int sz);
        if (sz == 1) return bo[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
        if (sz == 2) return {24'h0, w[8*bo +: 8]};
        return w;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Issue one request and measure the edges from acceptance to rsp_valid.
    task automatic run(input bit wr, input bit bc, input int sz, input logic [63:0] m,
                       input int base, input int stride, input int dsel, output int lat);
        @(negedge clk);
        req_write = wr; req_bcast = bc; req_size = 2'(sz); req_mask = m;
        for (int l = 0; l < L; l++) begin
            logic [15:0] a;
            a = 16'(base + l * stride);
            req_addr[l*16 +: 16] = a;
            if (dsel == 0)      req_wdata[l*32 +: 32] = fill(int'(a) >> 2);
            else if (dsel == 1) req_wdata[l*32 +: 32] = 32'hA000_0000 + 32'(l);
            else                req_wdata[l*32 +: 32] = 32'hB000_0000 + 32'(l);
        end
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 2000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        rdat = rsp_data;
    endtask

    // Compare every lane of the last index read against the fill pattern.
    task automatic check_read(input logic [63:0] m, input int base, input int stride,
                              input int sz, input string rq);
        int bad = 0;
        logic [31:0] fa = 0, fe = 0;
        for (int l = 0; l < L; l++) begin
            logic [15:0] a;
            logic [31:0] e;
            a = 16'(base + l * stride);
            e = m[l] ? ext(fill(int'(a) >> 2), a[1:0], sz) : 32'h0;
            if (rdat[l*32 +: 32] !== e) begin
                if (bad == 0) begin fa = rdat[l*32 +: 32]; fe = e; end
                bad++;
            end
        end
        chk(bad == 0, rq, fa, fe, "lane data");
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        int bad;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_bcast = 1'b0;
        req_size = 2'b00; req_mask = '0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(req_ready === 1'b1, "R10", 32'(req_ready), 1, "ready after reset");
        chk(rsp_valid === 1'b0, "R10", 32'(rsp_valid), 0, "valid after reset");

        // Fill all 64 KB with a known pattern (R1).
        for (int k = 0; k < 256; k++) begin
            run(1, 0, 0, {64{1'b1}}, k * 256, 4, 0, lat);
        end

        // Table walk of index reads.
        for (int v = 0; v < NV; v++) begin
            run(0, 0, T_SIZE[v], T_MASK[v], T_BASE[v], T_STRIDE[v], 0, lat);
            chk(lat == T_LAT[v], T_REQ[v], 32'(lat), 32'(T_LAT[v]), "latency");
            check_read(T_MASK[v], T_BASE[v], T_STRIDE[v], T_SIZE[v], T_REQ[v]);
        end

        // R9 one-cycle response pulse, then idle again.
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9",
            {30'h0, rsp_valid, req_ready}, 32'h1, "pulse end");

        // R1 both ends of the address space, via broadcast.
        run(0, 1, 0, 64'h1, 'hFFFC, 0, 0, lat);
        chk(rdat[63*32 +: 32] === fill('h3FFF), "R1", rdat[63*32 +: 32], fill('h3FFF), "top word");
        run(0, 1, 0, 64'h1, 0, 0, 0, lat);
        chk(rdat[7*32 +: 32] === fill(0), "R1", rdat[7*32 +: 32], fill(0), "bottom word");

        // R5 broadcast: latency 1, mask ignored, all lanes equal.
        run(0, 1, 0, 64'h1, 'h1234, 0, 0, lat);
        chk(lat == 1, "R5", 32'(lat), 1, "broadcast latency");
        bad = 0;
        for (int l = 0; l < L; l++) if (rdat[l*32 +: 32] !== fill('h48D)) bad++;
        chk(bad == 0, "R5", 32'(bad), 0, "lanes differing from broadcast word");
        run(1, 1, 2, 64'h0, 'h1237, 0, 2, lat);
        chk(rdat[40*32 +: 32] === ext(fill('h48D), 2'd3, 2), "R5", rdat[40*32 +: 32],
            ext(fill('h48D), 2'd3, 2), "broadcast byte, write flag and mask ignored");

        // R8 write then read back; write response is zero.
        run(1, 0, 0, {64{1'b1}}, 'h8000, 4, 1, lat);
        chk(lat == 2, "R8", 32'(lat), 2, "write latency");
        chk(rdat === '0, "R8", rdat[31:0], 0, "write response data");
        run(0, 0, 0, {64{1'b1}}, 'h8000, 4, 0, lat);
        bad = 0;
        for (int l = 0; l < L; l++) if (rdat[l*32 +: 32] !== 32'hA000_0000 + 32'(l)) bad++;
        chk(bad == 0, "R8", 32'(bad), 0, "lanes wrong after write");

        // R8 all lanes write one word (byte offset 1 ignored): lane 63 wins.
        run(1, 0, 0, {64{1'b1}}, 'h9001, 0, 2, lat);
        run(0, 1, 0, 64'h1, 'h9000, 0, 0, lat);
        chk(rdat[0 +: 32] === 32'hB000_003F, "R8", rdat[0 +: 32], 32'hB000_003F, "same-address write");

        // R7 masked write touches only the active lane.
        run(1, 0, 0, 64'h1, 'hA000, 4, 1, lat);
        run(0, 0, 0, {64{1'b1}}, 'hA000, 4, 0, lat);
        chk(rdat[0 +: 32] === 32'hA000_0000, "R7", rdat[0 +: 32], 32'hA000_0000, "active lane written");
        chk(rdat[5*32 +: 32] === fill(('hA000 >> 2) + 5), "R7", rdat[5*32 +: 32],
            fill(('hA000 >> 2) + 5), "inactive lane untouched");

        // R9 a request held while busy is ignored.
        @(negedge clk);
        req_write = 1'b0; req_bcast = 1'b0; req_size = 2'b00; req_mask = {64{1'b1}};
        for (int l = 0; l < L; l++) req_addr[l*16 +: 16] = 16'(l * 128);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_write = 1'b1;
        for (int l = 0; l < L; l++) begin
            req_addr[l*16 +: 16] = 16'hC000;
            req_wdata[l*32 +: 32] = 32'hDEAD_BEEF;
        end
        chk(req_ready === 1'b0, "R9", 32'(req_ready), 0, "ready while busy");
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 2000) begin @(negedge clk); lat++; end
        run(0, 1, 0, 64'h1, 'hC000, 0, 0, lat);
        chk(rdat[0 +: 32] === fill('h3000), "R9", rdat[0 +: 32], fill('h3000), "busy write ignored");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule